// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port

This block holds the per-pin configuration of a small general-purpose I/O port. It sits on a simple synchronous register bus with an address, write data, a write strobe and combinational read data. For each pin it keeps four bits: an output data bit, a direction bit, a pull enable bit and a function-select bit. From these bits it drives the pad controls: output enable, output value, pull enable and pull polarity.

The pad inputs pass through a two-stage synchronizer. The synchronized levels can be read back as an input-status register, and they also feed a held input path toward an alternate peripheral. When a pin's function-select bit is set, the peripheral supplies the value driven on that pin. The peripheral-facing input then tracks the pin. When the select bit is cleared again, that input freezes at the last level it saw.

The output data bit has two uses. When the pull is disabled it is the value driven on the pin. When the pull is enabled it chooses the pull polarity, and the pad driver is kept off.

Top module: `gpio_pin_port`

## Requirements
- R1: After reset, all four configuration registers read 0, `pad_oe`, `pad_pull_en`, `pad_pull_up` and `alt_in` are 0, and every pin is an input with no pull.
- R2: A write with `bus_we` high stores `bus_wdata` at the clock edge into the register the address selects: 1 for output data, 2 for direction, 3 for pull enable, 4 for function select. Reading that address returns the stored value. Addresses 5 to 7 read as 0.
- R3: Reading address 0 returns the pin levels as they were two clock edges earlier. A bit reads 1 for a high pin and 0 for a low pin.
- R4: A write to address 0 or to addresses 5 to 7 changes no register and no pad control.
- R5: `pad_oe` of a pin is 1 exactly when its direction bit is 1 and its pull enable bit is 0. This holds in either function.
- R6: `pad_o` of a pin equals its output data bit while its function-select bit is 0, and equals `alt_out` of that pin while its function-select bit is 1.
- R7: `pad_pull_en` mirrors the pull enable bits. `pad_pull_up` of a pin is its output data bit when the pull is enabled (1 pulls up, 0 pulls down) and 0 when it is not.
- R8: Writing the function-select register leaves the direction register and `pad_oe` unchanged.
- R9: While a pin's function-select bit is 1, its `alt_in` bit takes the synchronized pin level one edge after that level is readable at address 0 (three edges after the pin). While the select bit is 0, `alt_in` holds its last value.
- R10: A pin whose pull is enabled never has `pad_oe` high, even when its direction bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (3) | Register address |
| bus_wdata | input | PINS (8) | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | PINS (8) | Read data for `bus_addr` |
| pad_in | input | PINS (8) | Raw pin levels |
| alt_out | input | PINS (8) | Peripheral output value for each pin |
| pad_oe | output | PINS (8) | Pad driver enable |
| pad_o | output | PINS (8) | Pad output value |
| pad_pull_en | output | PINS (8) | Pull resistor enable |
| pad_pull_up | output | PINS (8) | Pull polarity, 1 for up |
| alt_in | output | PINS (8) | Held pin level toward the peripheral |

## Verification
Each result has a fixed latency:
- A configuration write changes the registers and pad controls at the edge that samples the strobe.
- Read data follows the address within the same cycle.
- Address 0 shows the pin level two edges after the pin changes.
- `alt_in` shows the pin level three edges after the pin changes.

The bench model advances its own register and synchronizer copies at the same edges as the design, so its expected values already include these delays. Stimulus changes 2 ns after a rising edge, and every output is compared at the falling edge, when both the design and the model have settled.

// File: rtl/gpio_pin_port.sv
module gpio_pin_port #(
  parameter int PINS = 8,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic [PINS-1:0] bus_wdata,
  input  logic            bus_we,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pad_in,
  input  logic [PINS-1:0] alt_out,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_o,
  output logic [PINS-1:0] pad_pull_en,
  output logic [PINS-1:0] pad_pull_up,
  output logic [PINS-1:0] alt_in
);
  localparam logic [AW-1:0] A_LEVEL = AW'(0);
  localparam logic [AW-1:0] A_DATA  = AW'(1);
  localparam logic [AW-1:0] A_DIR   = AW'(2);
  localparam logic [AW-1:0] A_PULL  = AW'(3);
  localparam logic [AW-1:0] A_FUNC  = AW'(4);

  logic [PINS-1:0] data_q, dir_q, pull_q, func_q;
  logic [PINS-1:0] meta_q, level_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      pull_q <= '0;
      func_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_DATA:  data_q <= bus_wdata;
        A_DIR:   dir_q  <= bus_wdata;
        A_PULL:  pull_q <= bus_wdata;
        A_FUNC:  func_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= '0;
      level_q <= '0;
      hold_q  <= '0;
    end else begin
      meta_q  <= pad_in;
      level_q <= meta_q;
      hold_q  <= (func_q & level_q) | (~func_q & hold_q);
    end
  end

  always_comb begin
    case (bus_addr)
      A_LEVEL: bus_rdata = level_q;
      A_DATA:  bus_rdata = data_q;
      A_DIR:   bus_rdata = dir_q;
      A_PULL:  bus_rdata = pull_q;
      A_FUNC:  bus_rdata = func_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pad_oe      = dir_q & ~pull_q;
  assign pad_o       = (func_q & alt_out) | (~func_q & data_q);
  assign pad_pull_en = pull_q;
  assign pad_pull_up = pull_q & data_q;
  assign alt_in      = hold_q;
endmodule

// File: rtl/gpio_pin_port_chk.sv
module gpio_pin_port_chk #(
  parameter int PINS = 8,
  parameter int AW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic [PINS-1:0] bus_rdata,
  input logic [PINS-1:0] pad_in,
  input logic [PINS-1:0] pad_oe,
  input logic [PINS-1:0] pad_pull_en,
  input logic [PINS-1:0] pad_pull_up,
  input logic [PINS-1:0] alt_in,
  input logic [PINS-1:0] func_q
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> (pad_oe == '0 && pad_pull_en == '0 && alt_in == '0));

  p_level_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && bus_addr == AW'(0)) |-> bus_rdata == $past(pad_in, 2));

  p_dead_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == AW'(0) || bus_addr > AW'(4)))
      |=> ($stable(pad_oe) && $stable(pad_pull_en) && $stable(pad_pull_up)));

  p_func_keeps_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(4)) |=> $stable(pad_oe));

  p_alt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1) |-> ((alt_in ^ $past(alt_in)) & ~$past(func_q)) == '0);

  p_pull_blocks_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pull_en) == '0);
endmodule

bind gpio_pin_port gpio_pin_port_chk #(.PINS(PINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
  .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
  .alt_in(alt_in), .func_q(func_q)
);

// File: tb/sim_gpio_pin_port.sv
module sim_gpio_pin_port;
  localparam int PINS = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [PINS-1:0] bus_wdata = '0;
  logic bus_we = 1'b0;
  logic [PINS-1:0] bus_rdata, pad_in = '0, alt_out = '0;
  logic [PINS-1:0] pad_oe, pad_o, pad_pull_en, pad_pull_up, alt_in;

  int n_chk = 0, n_bad = 0, ticks = 0;

  always #4 clk = ~clk;

  gpio_pin_port #(.PINS(PINS), .AW(AW)) u0 (
    .clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_rdata,
    .pad_in, .alt_out, .pad_oe, .pad_o, .pad_pull_en, .pad_pull_up, .alt_in);

  logic [PINS-1:0] m_reg [1:4];
  logic [PINS-1:0] m_q1, m_q2, m_alt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= 4; i++) m_reg[i] <= '0;
      m_q1 <= '0; m_q2 <= '0; m_alt <= '0;
    end else begin
      if (bus_we && bus_addr >= 1 && bus_addr <= 4) m_reg[bus_addr] <= bus_wdata;
      m_q1 <= pad_in;
      m_q2 <= m_q1;
      for (int b = 0; b < PINS; b++)
        if (m_reg[4][b]) m_alt[b] <= m_q2[b];
    end
  end

  task automatic check(string req, logic [PINS-1:0] act, logic [PINS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [PINS-1:0] exp_rdata(logic [AW-1:0] a);
    if (a == 0) return m_q2;
    if (a <= 4) return m_reg[a];
    return '0;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic [PINS-1:0] eo;
      for (int b = 0; b < PINS; b++)
        eo[b] = m_reg[4][b] ? alt_out[b] : m_reg[1][b];
      check("R5/R10 pad_oe", pad_oe, m_reg[2] & ~m_reg[3]);
      check("R6 pad_o", pad_o, eo);
      check("R7 pad_pull_en", pad_pull_en, m_reg[3]);
      check("R7 pad_pull_up", pad_pull_up, m_reg[3] & m_reg[1]);
      check("R9 alt_in", alt_in, m_alt);
      check("R2/R3 bus_rdata", bus_rdata, exp_rdata(bus_addr));
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      summary();
    end
  end

  task automatic wr(int a, logic [PINS-1:0] v);
    @(posedge clk); #2;
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = v;
    @(posedge clk); #2;
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, logic [PINS-1:0] v, string req);
    @(posedge clk); #2;
    bus_addr = AW'(a);
    @(negedge clk);
    check(req, bus_rdata, v);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    void'($urandom(7));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_pull_en", pad_pull_en, '0);
    check("R1 alt_in", alt_in, '0);
    for (int a = 1; a <= 4; a++) rd(a, '0, "R1 config register");

    wr(1, 8'hA5); wr(2, 8'h0F); wr(3, 8'h03); wr(4, 8'h30);
    rd(1, 8'hA5, "R2 data"); rd(2, 8'h0F, "R2 dir");
    rd(3, 8'h03, "R2 pull"); rd(4, 8'h30, "R2 func"); rd(6, 8'h00, "R2 unmapped");

    // R4: writes to the level address and unmapped addresses are ignored
    wr(0, 8'hFF); wr(5, 8'hFF); wr(7, 8'h5A);
    rd(1, 8'hA5, "R4 data kept"); rd(2, 8'h0F, "R4 dir kept");
    rd(3, 8'h03, "R4 pull kept"); rd(4, 8'h30, "R4 func kept");

    // R8: the function-select write keeps the direction
    wr(2, 8'h3C); wr(4, 8'hFF);
    rd(2, 8'h3C, "R8 dir after func write");
    @(negedge clk); check("R8 pad_oe", pad_oe, 8'h3C & ~8'h03);

    // R9: hold after deselect
    wr(4, 8'h01); pad_in = 8'h01; idle(4);
    @(negedge clk); check("R9 alt_in follows", alt_in[0], 1'b1);
    wr(4, 8'h00); pad_in = 8'h00; idle(5);
    @(negedge clk); check("R9 alt_in held", alt_in[0], 1'b1);

    // R3: a pin edge appears at address 0 after two edges
    bus_addr = '0; pad_in = 8'h81; @(posedge clk); @(posedge clk); #2;
    @(negedge clk); check("R3 level", bus_rdata, 8'h81);

    // R10: pull on output pins keeps the driver off
    wr(2, 8'hFF); wr(3, 8'hFF); wr(1, 8'h0F);
    @(negedge clk);
    check("R10 pad_oe", pad_oe, 8'h00);
    check("R7 pull_up", pad_pull_up, 8'h0F);

    for (int k = 0; k < 600; k++) begin
      @(posedge clk); #2;
      pad_in = PINS'($urandom);
      alt_out = PINS'($urandom);
      bus_addr = AW'($urandom);
      bus_wdata = PINS'($urandom);
      bus_we = ($urandom % 3) == 0;
    end
    #2 bus_we = 1'b0;
    idle(4);
    summary();
  end
endmodule